// File: doc/BRIEF.md
# Sequential Keypad Combination Lock

This block is a synchronous door lock that opens after a fixed-length sequence of code digits arrives in the right order. The digits come in on a shared value bus. Each one is marked by a single-cycle entry strobe. The stored code lives in a bank of loadable registers, written from the same bus by one write strobe per digit. A one-hot selector picks the digit expected next, and an equality comparator checks the entered value against it.

The controller keeps its state one-hot. The low bits of the state act as the selector, and the top bit is the door output, so no output decode stage is needed. A wrong digit parks the controller in an all-zero error state. The open state and the error state both ignore further entries; only reset leaves them. Reset is synchronous and active high. It never touches the code registers. Before the first write, those registers hold a build-time default code.

Top module: `keypad_lock`

## Requirements
- R1: While `rst` is high, the next clock edge puts the controller in the first-digit state and `door_open` reads 0. Reset takes priority over `digit_new` and over every `code_wr` strobe, so a write strobe applied during reset leaves that code register unchanged.
- R2: Before any write, the stored code is 3, 4, 2. Digit 0 is entered first and digit 2 last.
- R3: A high `code_wr[i]` at a clock edge stores `digit_val` into code register i. Code registers keep their contents through reset.
- R4: When `digit_new` is high on three successive entries and each `digit_val` equals code digits 0, 1 and 2 in that order, `door_open` goes to 1 after the edge of the third entry. It stays 0 after the first and second entries.
- R5: While `digit_new` is low, the controller holds its state, whatever value is on `digit_val`.
- R6: An entry whose value differs from the expected digit, at any position, sends the controller to the error state with `door_open` at 0. Later entries, including the complete correct code, leave the door closed until reset.
- R7: Once `door_open` is 1, it stays 1 through any further entries, right or wrong, until reset.
- R8: When an entry and a write to the expected code register occur in the same cycle, the entry is compared against the register's previous contents. The write takes effect for later entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_val | input | DIGIT_W (4) | Value bus for entered digits and code writes |
| digit_new | input | 1 | One-cycle strobe marking an entered digit |
| code_wr | input | NUM_DIGITS (3) | Per-register write strobes for the stored code |
| door_open | output | 1 | 1 when the lock is open, 0 when closed |

## Verification
The hardest case to reach from the ports is a write to a code register in the same cycle as an entry that is compared against that register. The outcome depends on whether the comparator sees the old or the new contents. The stimulus first sets a known code. It then drives a different value on the bus together with the entry strobe and the matching write strobe. The door must stay closed, because the old digit is compared. After a reset, the new value must open the lock. A write strobe is also held during reset to show that reset overrides it. The main sweep tries every wrong value at every digit position for several codes, so each position's path to the error state is exercised.

// File: rtl/keypad_lock_pkg.sv
package keypad_lock_pkg;
  localparam int unsigned DIGIT_W_DEF    = 4;
  localparam int unsigned NUM_DIGITS_DEF = 3;

  // True when the vector has at most one bit set (legal one-hot or the all-zero error code).
  function automatic logic at_most_one(input logic [15:0] v);
    return (v & (v - 16'd1)) == 16'd0;
  endfunction
endpackage

// File: rtl/keypad_lock_code_bank.sv
module keypad_lock_code_bank #(
  parameter int unsigned                W    = 4,
  parameter int unsigned                N    = 3,
  parameter logic [N*W-1:0]             INIT = {4'd2, 4'd4, 4'd3}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          din,
  input  logic [N-1:0]          wr,
  output logic [N-1:0][W-1:0]   code
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q = INIT[i*W +: W];
    always_ff @(posedge clk) begin
      if (!rst && wr[i]) q <= din;
    end
    assign code[i] = q;
  end
endmodule

// File: rtl/keypad_lock_select.sv
module keypad_lock_select #(
  parameter int unsigned W = 4,
  parameter int unsigned N = 3
) (
  input  logic [N-1:0][W-1:0] code,
  input  logic [N-1:0]        sel,
  input  logic [W-1:0]        din,
  output logic                match
);
  logic [N-1:0][W-1:0] masked;
  logic [W-1:0]        picked;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = code[i] & {W{sel[i]}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++) picked = picked | masked[i];
  end

  assign match = (|sel) && (picked == din);
endmodule

// File: rtl/keypad_lock_ctrl.sv
module keypad_lock_ctrl #(
  parameter int unsigned N  = 3,
  localparam int unsigned SW = N + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          entry,
  input  logic          match,
  output logic [SW-1:0] state
);
  import keypad_lock_pkg::*;

  localparam logic [SW-1:0] ST_FIRST = SW'(1);
  localparam logic [SW-1:0] ST_ERR   = '0;

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic          legal;

  assign legal = at_most_one(16'(state_q));

  always_comb begin
    state_d = state_q;
    if (!legal) begin
      state_d = ST_ERR;
    end else if (state_q[SW-1] || state_q == ST_ERR) begin
      state_d = state_q;
    end else if (entry) begin
      state_d = match ? (state_q << 1) : ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FIRST;
    else     state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/keypad_lock.sv
module keypad_lock #(
  parameter int unsigned    DIGIT_W      = keypad_lock_pkg::DIGIT_W_DEF,
  parameter int unsigned    NUM_DIGITS   = keypad_lock_pkg::NUM_DIGITS_DEF,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] DEFAULT_CODE = {4'd2, 4'd4, 4'd3}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIGIT_W-1:0]    digit_val,
  input  logic                  digit_new,
  input  logic [NUM_DIGITS-1:0] code_wr,
  output logic                  door_open
);
  localparam int unsigned SW = NUM_DIGITS + 1;

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] code;
  logic [SW-1:0]                      state_q;
  logic                               match;

  keypad_lock_code_bank #(.W(DIGIT_W), .N(NUM_DIGITS), .INIT(DEFAULT_CODE)) u_bank (
    .clk (clk), .rst (rst), .din (digit_val), .wr (code_wr), .code (code)
  );

  keypad_lock_select #(.W(DIGIT_W), .N(NUM_DIGITS)) u_sel (
    .code (code), .sel (state_q[NUM_DIGITS-1:0]), .din (digit_val), .match (match)
  );

  keypad_lock_ctrl #(.N(NUM_DIGITS)) u_ctrl (
    .clk (clk), .rst (rst), .entry (digit_new), .match (match), .state (state_q)
  );

  assign door_open = state_q[SW-1];
endmodule

// File: rtl/keypad_lock_checker.sv
module keypad_lock_checker #(
  parameter int unsigned N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         digit_new,
  input logic         door_open,
  input logic [N:0]   state
);
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (state == (N+1)'(1)) && !door_open);

  // R6: only one-hot or all-zero encodings are ever held
  a_r6_encoding: assert property (@(posedge clk) disable iff (rst) $onehot0(state));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst) !digit_new |=> $stable(state));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst) (state == '0) |=> (state == '0));

  a_r7_open_sticky: assert property (@(posedge clk) disable iff (rst) door_open |=> door_open);

  // R4: the door opens only from the last-digit state on an entry
  a_r4_open_path: assert property (@(posedge clk) disable iff (rst)
    $rose(door_open) |-> ($past(state[N-1]) && $past(digit_new)));
endmodule

bind keypad_lock keypad_lock_checker #(.N(NUM_DIGITS)) u_chk (
  .clk (clk), .rst (rst), .digit_new (digit_new), .door_open (door_open), .state (state_q)
);

// File: tb/keypad_lock_bench.sv
`timescale 1ns/1ps
module keypad_lock_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dval = '0;
  logic       dnew = 1'b0;
  logic [2:0] wr = '0;
  logic       door_open;

  int checks = 0;
  int errors = 0;
  logic [3:0] cd [3];

  always #2 clk = ~clk;

  keypad_lock u_keypad_lock (
    .clk (clk), .rst (rst), .digit_val (dval), .digit_new (dnew),
    .code_wr (wr), .door_open (door_open)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s door_open actual=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // Called at a negedge; applies inputs for one edge, returns at the next negedge.
  task automatic step(input logic [3:0] v, input logic n, input logic [2:0] w);
    dval = v; dnew = n; wr = w;
    @(negedge clk);
    dnew = 1'b0; wr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_code(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    step(a, 1'b0, 3'b001);
    step(b, 1'b0, 3'b010);
    step(c, 1'b0, 3'b100);
    cd[0] = a; cd[1] = b; cd[2] = c;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(door_open, 1'b0, "R1 reset closed");

    // R2: default code 3,4,2 before any write
    step(4'd3, 1'b1, 3'b000); check(door_open, 1'b0, "R2 digit0");
    step(4'd4, 1'b1, 3'b000); check(door_open, 1'b0, "R2 digit1");
    step(4'd2, 1'b1, 3'b000); check(door_open, 1'b1, "R2 default opens");
    do_reset();
    check(door_open, 1'b0, "R1 reset closes open door");

    // Sweep over several codes
    for (int k = 0; k < 6; k++) begin
      logic [3:0] a, b, c;
      a = 4'((k*5 + 1) % 16);
      b = 4'((k*7 + 3) % 16);
      c = 4'((k*11 + 9) % 16);
      load_code(a, b, c);
      do_reset();  // R3: contents must survive reset
      step(cd[0], 1'b1, 3'b000); check(door_open, 1'b0, "R4 after first");
      step(4'hF ^ cd[1], 1'b0, 3'b000); check(door_open, 1'b0, "R5 no strobe");
      step(cd[1], 1'b1, 3'b000); check(door_open, 1'b0, "R4 after second");
      step(~cd[2], 1'b0, 3'b000); check(door_open, 1'b0, "R5 no strobe");
      step(cd[2], 1'b1, 3'b000); check(door_open, 1'b1, "R3 R4 opens");
      step(~cd[0], 1'b1, 3'b000); check(door_open, 1'b1, "R7 wrong digit keeps open");
      step(cd[0], 1'b1, 3'b000); check(door_open, 1'b1, "R7 further digit keeps open");
      do_reset();
      check(door_open, 1'b0, "R1 reset from open");

      for (int p = 0; p < 3; p++) begin
        for (int v = 0; v < 16; v++) begin
          if (4'(v) != cd[p]) begin
            do_reset();
            for (int q = 0; q < p; q++) step(cd[q], 1'b1, 3'b000);
            step(4'(v), 1'b1, 3'b000);
            check(door_open, 1'b0, "R6 wrong digit closed");
            for (int q = 0; q < 3; q++) begin
              step(cd[q], 1'b1, 3'b000);
              check(door_open, 1'b0, "R6 error sticky");
            end
          end
        end
      end
    end

    // R8: same-cycle write and entry compares against old contents
    load_code(4'd6, 4'd7, 4'd8);
    do_reset();
    step(4'd9, 1'b1, 3'b001);
    check(door_open, 1'b0, "R8 old digit compared");
    step(4'd7, 1'b1, 3'b000);
    step(4'd8, 1'b1, 3'b000);
    check(door_open, 1'b0, "R8 error after old compare");
    do_reset();
    step(4'd9, 1'b1, 3'b000);
    step(4'd7, 1'b1, 3'b000);
    step(4'd8, 1'b1, 3'b000);
    check(door_open, 1'b1, "R8 write took effect");

    // R1: write strobe during reset is ignored
    rst = 1'b1;
    step(4'd1, 1'b0, 3'b001);
    rst = 1'b0;
    check(door_open, 1'b0, "R1 reset closed");
    step(4'd9, 1'b1, 3'b000);
    step(4'd7, 1'b1, 3'b000);
    step(4'd8, 1'b1, 3'b000);
    check(door_open, 1'b1, "R1 write blocked by reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule